// File: doc/BRIEF.md
# Microprogrammed Accumulator Processor Control Unit

This block is a small single-bus accumulator processor whose every register transfer is commanded by a microprogram ROM. The datapath has a program counter, a memory address register, a memory data register, an instruction register, an accumulator and a four-function ALU. All of them meet on one internal bus. Program and data come from one shared memory through one path: a chip-select strobe, a read strobe, an address and a read-data input.

A micro-program counter steps through stored microinstructions. Each microinstruction is a 16-bit control word that holds for exactly one clock. Each instruction runs as a three-step fetch followed by an execute routine. The step that loads the instruction register dispatches the micro-PC from the opcode. The last execute word carries an end bit that sends the micro-PC back to the first fetch step. There is no microbranching. Adding an instruction therefore means adding ROM words and a dispatch entry.

The instruction word is 16 bits: bits 15:12 hold the opcode and bits 11:0 hold the address. Opcode 0 loads the accumulator from memory. Opcode 1 adds a memory word to the accumulator. Every other opcode does nothing.

Top module: `ucpu_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the program counter, the accumulator and the micro-PC, so the first cycle after reset shows the first fetch word.
- R2: Control bits 0 (PC to bus), 2 (address field to bus), 7 (MDR to bus) and 12 (ALU to bus) are the bus sources. At most one of them is set in any cycle.
- R3: Fetch step 1 outputs control word 0x010B: bit 0 PC to bus, bit 1 load MAR, bit 3 load PC, bit 8 selects PC+1 as the PC input. In the next cycle pc_o has advanced by one, modulo 2^12.
- R4: Fetch step 2 outputs 0x2040, which is bit 6 chip-select plus bit 13 read. During that step mem_addr equals the address of the instruction being fetched.
- R5: Fetch step 3 outputs 0x4090: bit 7 MDR to bus, bit 4 load IR, bit 14 dispatch. The next step is the execute routine selected by the opcode in bits 15:12.
- R6: Opcode 0 (load) runs 0x0006 (address field to bus, load MAR), then 0x2040 with mem_addr equal to the 12-bit address field, then 0x80A0 (MDR to bus, load ACC, bit 15 end). The accumulator then holds the memory word.
- R7: Opcode 1 (add) runs 0x0006, then 0x2040 with mem_addr equal to the address field, then 0x8220 (load ACC, bit 9 selects the ALU result, bits 11:10 = 00 add, end). The accumulator then holds ACC + M[addr] modulo 2^16.
- R8: Any opcode from 2 to 15 runs a single word 0x8000 (end only) and leaves the accumulator unchanged.
- R9: After a word with bit 15 set, the next cycle is fetch step 1. A load or add instruction therefore takes 6 cycles and any other opcode takes 4.
- R10: mem_cs is high only together with mem_rd, and only in the two memory-read steps. The MDR captures mem_rdata at the clock edge that ends such a step.
- R11: The program counter wraps from 4095 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_cs | output | 1 | Memory chip-select (control bit 6) |
| mem_rd | output | 1 | Memory read strobe (control bit 13) |
| mem_addr | output | ADDR_W | Memory address, driven from the MAR |
| mem_rdata | input | DATA_W | Read data; must be valid in the chip-select cycle |
| ctrl_o | output | 16 | Current microinstruction control word |
| acc_o | output | DATA_W | Accumulator |
| pc_o | output | ADDR_W | Program counter |

## Verification
The control word changes at every clock edge, so the bench compares ctrl_o once per cycle, sampling on the falling edge against the step it expects. mem_addr is compared in the step where chip-select is high: the second fetch step and the second execute step. Accumulator and PC results are due at the first fetch step that follows the end word. That is 6 cycles after the first fetch step for load and add, and 4 cycles for the other opcodes. The bench's reference model advances by exactly those counts before it compares.

// File: rtl/ucpu_pkg.sv
package ucpu_pkg;
    localparam int CTRL_W    = 16;
    localparam int C_PC_OUT  = 0;
    localparam int C_MAR_LD  = 1;
    localparam int C_ADR_OUT = 2;
    localparam int C_PC_LD   = 3;
    localparam int C_IR_LD   = 4;
    localparam int C_ACC_LD  = 5;
    localparam int C_CS      = 6;
    localparam int C_MDR_OUT = 7;
    localparam int C_PC_SEL  = 8;
    localparam int C_ACC_SEL = 9;
    localparam int C_ALU_LO  = 10;
    localparam int C_ALU_HI  = 11;
    localparam int C_ALU_OUT = 12;
    localparam int C_RD      = 13;
    localparam int C_MAP     = 14;
    localparam int C_END     = 15;

    typedef enum logic [1:0] {ALU_ADD = 2'd0, ALU_SUB = 2'd1,
                              ALU_MUL = 2'd2, ALU_DIV = 2'd3} alu_op_e;
endpackage

// File: rtl/ucpu_urom.sv
module ucpu_urom
    import ucpu_pkg::*;
#(
    parameter int UPC_W     = 4,
    parameter int ENT_LOAD  = 3,
    parameter int ENT_ADD   = 6,
    parameter int ENT_NOP   = 9
) (
    input  logic [UPC_W-1:0]  upc,
    output logic [CTRL_W-1:0] ctrl
);
    localparam logic [UPC_W-1:0] L0 = UPC_W'(ENT_LOAD);
    localparam logic [UPC_W-1:0] A0 = UPC_W'(ENT_ADD);
    localparam logic [UPC_W-1:0] N0 = UPC_W'(ENT_NOP);

    always_comb begin
        ctrl = '0;
        case (upc)
            UPC_W'(0): begin
                ctrl[C_PC_OUT] = 1'b1;
                ctrl[C_MAR_LD] = 1'b1;
                ctrl[C_PC_LD]  = 1'b1;
                ctrl[C_PC_SEL] = 1'b1;
            end
            UPC_W'(1): begin
                ctrl[C_CS] = 1'b1;
                ctrl[C_RD] = 1'b1;
            end
            UPC_W'(2): begin
                ctrl[C_MDR_OUT] = 1'b1;
                ctrl[C_IR_LD]   = 1'b1;
                ctrl[C_MAP]     = 1'b1;
            end
            L0, A0: begin
                ctrl[C_ADR_OUT] = 1'b1;
                ctrl[C_MAR_LD]  = 1'b1;
            end
            L0 + UPC_W'(1), A0 + UPC_W'(1): begin
                ctrl[C_CS] = 1'b1;
                ctrl[C_RD] = 1'b1;
            end
            L0 + UPC_W'(2): begin
                ctrl[C_MDR_OUT] = 1'b1;
                ctrl[C_ACC_LD]  = 1'b1;
                ctrl[C_END]     = 1'b1;
            end
            A0 + UPC_W'(2): begin
                ctrl[C_ACC_LD]  = 1'b1;
                ctrl[C_ACC_SEL] = 1'b1;
                ctrl[C_ALU_HI:C_ALU_LO] = ALU_ADD;
                ctrl[C_END]     = 1'b1;
            end
            N0: ctrl[C_END] = 1'b1;
            default: ctrl[C_END] = 1'b1;
        endcase
    end
endmodule

// File: rtl/ucpu_useq.sv
module ucpu_useq #(
    parameter int UPC_W    = 4,
    parameter int OP_W     = 4,
    parameter int ENT_LOAD = 3,
    parameter int ENT_ADD  = 6,
    parameter int ENT_NOP  = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             end_i,
    input  logic             map_i,
    input  logic [OP_W-1:0]  opcode_i,
    output logic [UPC_W-1:0] upc_o
);
    logic [UPC_W-1:0] upc_d, upc_q;

    always_comb begin
        upc_d = upc_q + UPC_W'(1);
        if (end_i) begin
            upc_d = '0;
        end else if (map_i) begin
            case (opcode_i)
                OP_W'(0): upc_d = UPC_W'(ENT_LOAD);
                OP_W'(1): upc_d = UPC_W'(ENT_ADD);
                default:  upc_d = UPC_W'(ENT_NOP);
            endcase
        end
        if (rst) upc_d = '0;
    end

    always_ff @(posedge clk) begin
        upc_q <= upc_d;
    end

    assign upc_o = upc_q;
endmodule

// File: rtl/ucpu_alu.sv
module ucpu_alu
    import ucpu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y
);
    logic [2*W-1:0] prod;

    always_comb begin
        prod = {{W{1'b0}}, a} * {{W{1'b0}}, b};
        case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_MUL: y = prod[W-1:0];
            default: y = (b == '0) ? '1 : a / b;
        endcase
    end
endmodule

// File: rtl/ucpu_ctrl.sv
module ucpu_ctrl
    import ucpu_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    output logic              mem_cs,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic [DATA_W-1:0] acc_o,
    output logic [ADDR_W-1:0] pc_o
);
    localparam int OP_W     = DATA_W - ADDR_W;
    localparam int UPC_W    = 4;
    localparam int ENT_LOAD = 3;
    localparam int ENT_ADD  = 6;
    localparam int ENT_NOP  = 9;

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] mar;
        logic [DATA_W-1:0] mdr;
        logic [DATA_W-1:0] ir;
        logic [DATA_W-1:0] acc;
    } dp_t;

    dp_t               dp_d, dp_q;
    logic [UPC_W-1:0]  upc;
    logic [CTRL_W-1:0] ctrl;
    logic [DATA_W-1:0] bus;
    logic [DATA_W-1:0] alu_y;

    ucpu_urom #(.UPC_W(UPC_W), .ENT_LOAD(ENT_LOAD), .ENT_ADD(ENT_ADD),
                .ENT_NOP(ENT_NOP)) u_rom (.upc(upc), .ctrl(ctrl));

    ucpu_useq #(.UPC_W(UPC_W), .OP_W(OP_W), .ENT_LOAD(ENT_LOAD),
                .ENT_ADD(ENT_ADD), .ENT_NOP(ENT_NOP)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .end_i    (ctrl[C_END]),
        .map_i    (ctrl[C_MAP]),
        .opcode_i (bus[DATA_W-1 -: OP_W]),
        .upc_o    (upc)
    );

    ucpu_alu #(.W(DATA_W)) u_alu (
        .a  (dp_q.acc),
        .b  (dp_q.mdr),
        .op (alu_op_e'(ctrl[C_ALU_HI:C_ALU_LO])),
        .y  (alu_y)
    );

    // shared bus: sources are OR-combined, the microprogram keeps them exclusive
    always_comb begin
        bus = ({DATA_W{ctrl[C_PC_OUT]}}  & DATA_W'(dp_q.pc))
            | ({DATA_W{ctrl[C_ADR_OUT]}} & DATA_W'(dp_q.ir[ADDR_W-1:0]))
            | ({DATA_W{ctrl[C_MDR_OUT]}} & dp_q.mdr)
            | ({DATA_W{ctrl[C_ALU_OUT]}} & alu_y);
    end

    always_comb begin
        dp_d = dp_q;
        if (ctrl[C_MAR_LD]) dp_d.mar = bus[ADDR_W-1:0];
        if (ctrl[C_PC_LD])
            dp_d.pc = ctrl[C_PC_SEL] ? dp_q.pc + ADDR_W'(1) : bus[ADDR_W-1:0];
        if (ctrl[C_IR_LD]) dp_d.ir = bus;
        if (ctrl[C_ACC_LD]) dp_d.acc = ctrl[C_ACC_SEL] ? alu_y : bus;
        if (ctrl[C_CS] && ctrl[C_RD]) dp_d.mdr = mem_rdata;
        if (rst) dp_d = '0;
    end

    always_ff @(posedge clk) begin
        dp_q <= dp_d;
    end

    assign mem_cs   = ctrl[C_CS];
    assign mem_rd   = ctrl[C_RD];
    assign mem_addr = dp_q.mar;
    assign ctrl_o   = ctrl;
    assign acc_o    = dp_q.acc;
    assign pc_o     = dp_q.pc;
endmodule

// File: rtl/ucpu_ctrl_chk.sv
module ucpu_ctrl_chk #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_cs,
    input logic              mem_rd,
    input logic [15:0]       ctrl_o,
    input logic [DATA_W-1:0] acc_o,
    input logic [ADDR_W-1:0] pc_o
);
    // R1
    reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pc_o == '0 && acc_o == '0 && ctrl_o == 16'h010B));

    // R2
    one_bus_source_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ctrl_o[0], ctrl_o[2], ctrl_o[7], ctrl_o[12]}));

    // R3
    pc_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_o[0] && ctrl_o[3] && ctrl_o[8])
        |=> pc_o == ADDR_W'($past(pc_o) + ADDR_W'(1)));

    // R8
    nop_keeps_acc_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_o == 16'h8000) |=> $stable(acc_o));

    // R9
    end_to_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_o[15] |=> ctrl_o == 16'h010B);

    // R10
    cs_with_read_chk: assert property (@(posedge clk) disable iff (rst)
        mem_cs |-> mem_rd);
endmodule

bind ucpu_ctrl ucpu_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .mem_cs(mem_cs), .mem_rd(mem_rd),
    .ctrl_o(ctrl_o), .acc_o(acc_o), .pc_o(pc_o));

// File: tb/tb_ucpu_ctrl.sv
module tb_ucpu_ctrl;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 16;
    localparam time HALF  = 2.5ns;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              mem_cs, mem_rd;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_rdata;
    logic [15:0]       ctrl_o;
    logic [DATA_W-1:0] acc_o;
    logic [ADDR_W-1:0] pc_o;

    logic [15:0] mem [256];
    int n_chk = 0;
    int n_bad = 0;
    logic [ADDR_W-1:0] pc_m;
    logic [DATA_W-1:0] acc_m;

    always #HALF clk = ~clk;

    ucpu_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst(rst), .mem_cs(mem_cs), .mem_rd(mem_rd),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .ctrl_o(ctrl_o),
        .acc_o(acc_o), .pc_o(pc_o));

    always_comb mem_rdata = mem_cs ? mem[mem_addr[7:0]] : '0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exec_word(input logic [3:0] op, input int step);
        if (op > 4'd1) return 16'h8000;
        if (step == 0) return 16'h0006;
        if (step == 1) return 16'h2040;
        return (op == 4'd0) ? 16'h80A0 : 16'h8220;
    endfunction

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        pc_m = '0;
        acc_m = '0;
        // R1: cleared state visible in the first cycle after reset
        chk(pc_o == '0, "R1 pc", 32'(pc_o), 0);
        chk(acc_o == '0, "R1 acc", 32'(acc_o), 0);
        chk(ctrl_o == 16'h010B, "R1 first word", 32'(ctrl_o), 32'h010B);
    endtask

    // run one instruction from fetch step 1; sampling at falling edges
    task automatic run_instr(input bit detail);
        logic [15:0] w;
        logic [3:0]  op;
        logic [11:0] a;
        logic [15:0] dv;
        int          n_ex;
        w  = mem[pc_m[7:0]];
        op = w[15:12];
        a  = w[11:0];
        dv = mem[a[7:0]];
        n_ex = (op > 4'd1) ? 1 : 3;
        if (detail) begin
            chk(ctrl_o == 16'h010B, "R3 fetch1", 32'(ctrl_o), 32'h010B);
            chk($onehot0({ctrl_o[0], ctrl_o[2], ctrl_o[7], ctrl_o[12]}), "R2 bus",
                32'(ctrl_o), 0);
        end
        @(negedge clk);
        if (detail) begin
            chk(pc_o == pc_m + 12'd1, "R3 pc+1", 32'(pc_o), 32'(pc_m + 12'd1));
            chk(ctrl_o == 16'h2040, "R4 fetch2", 32'(ctrl_o), 32'h2040);
            chk(mem_addr == pc_m, "R4 addr", 32'(mem_addr), 32'(pc_m));
            chk(mem_cs && mem_rd, "R10 cs+rd", 32'({mem_cs, mem_rd}), 3);
        end
        @(negedge clk);
        if (detail) begin
            chk(ctrl_o == 16'h4090, "R5 fetch3", 32'(ctrl_o), 32'h4090);
            chk(!mem_cs, "R10 no cs", 32'(mem_cs), 0);
        end
        @(negedge clk);
        for (int s = 0; s < n_ex; s++) begin
            if (detail) begin
                chk(ctrl_o == exec_word(op, s), (op == 0) ? "R6 exec" :
                    (op == 1) ? "R7 exec" : "R8 exec", 32'(ctrl_o),
                    32'(exec_word(op, s)));
                if (s == 1)
                    chk(mem_addr == a, "R6/R7 operand addr", 32'(mem_addr), 32'(a));
                chk($onehot0({ctrl_o[0], ctrl_o[2], ctrl_o[7], ctrl_o[12]}), "R2 bus",
                    32'(ctrl_o), 0);
            end
            @(negedge clk);
        end
        pc_m = pc_m + 12'd1;
        if (op == 4'd0) acc_m = dv;
        else if (op == 4'd1) acc_m = acc_m + dv;
        if (detail || pc_m == '0) begin
            chk(ctrl_o == 16'h010B, "R9 back to fetch", 32'(ctrl_o), 32'h010B);
            chk(acc_o == acc_m, (op == 0) ? "R6 acc" : (op == 1) ? "R7 acc" :
                "R8 acc", 32'(acc_o), 32'(acc_m));
            chk(pc_o == pc_m, "R11 pc", 32'(pc_o), 32'(pc_m));
        end
    endtask

    task automatic fill_random();
        for (int i = 0; i < 256; i++) mem[i] = 16'($urandom);
        for (int i = 0; i < 100; i++) begin
            int r;
            r = $urandom % 4;
            mem[i][15:12] = (r < 2) ? 4'(r) : 4'(2 + $urandom % 14);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) mem[i] = '0;
        // directed: load then add with 16-bit wrap (R6, R7)
        mem[0] = 16'h0080; mem[1] = 16'h1081; mem[2] = 16'h2000;
        mem[3] = 16'h1F81;
        mem[8'h80] = 16'hFFFF; mem[8'h81] = 16'h0002;
        do_reset();
        for (int k = 0; k < 4; k++) run_instr(1'b1);
        chk(acc_o == 16'h0003, "R7 wrap add", 32'(acc_o), 3);

        // random programs
        for (int p = 0; p < 3; p++) begin
            fill_random();
            do_reset();
            for (int k = 0; k < 100; k++) run_instr(1'b1);
        end

        // reset in the middle of an instruction (R1)
        mem[0] = 16'h0005; mem[5] = 16'h1234;
        do_reset();
        run_instr(1'b1);
        repeat (2) @(negedge clk);
        do_reset();

        // R11: program counter wraps after 4096 no-op instructions
        for (int i = 0; i < 256; i++) mem[i] = 16'hF0A5;
        do_reset();
        for (int k = 0; k < 4096; k++) run_instr(1'b0);
        run_instr(1'b1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule